// File: doc/BRIEF.md
# Embedded State-Mode Trace Capture Core

This block is an on-chip logic analyzer for a large design. It samples a bus of probed internal nodes on every rising edge of the design clock and keeps those samples in an internal RAM trace buffer. No sub-cycle timing between signals is recorded. A run-time trigger built from a compare value and a don't-care mask decides where the capture stops. The buffer wraps while the core waits for the trigger, so the history before the trigger is kept. A programmable number of samples after the trigger is also stored.

A host-side debug port stands in for a JTAG bridge. The host writes the compare value, the mask, the post-trigger count and an arm command. It polls a status word and then reads the buffer one address at a time. The core needs no extra package pins. Trace depth is set by the RAM size parameter.

Top module: `trc_capture_core`

## Requirements
- R1: After reset, `stat_state` is 0 (idle), `stat_trig_idx` is 0 and `rd_valid` is 0.
- R2: The status encoding is 0 = idle, 1 = armed, 2 = triggered, 3 = done. In idle, no probe value causes a trigger or a capture until the core is armed.
- R3: While armed, a sample taken at a clock edge triggers when `(probe & mask) == (value & mask)`. A mask bit of 0 makes that probe bit don't-care.
- R4: While armed or triggered, each clock edge writes the probe value to buffer index `wr_ptr`. The first sample after arming goes to index 0, and the index wraps modulo DEPTH.
- R5: After the trigger sample, exactly P more samples are stored, with P being the post-trigger count clamped to DEPTH-1. The state becomes done at the edge that stores the last of them. With P = 0 the state goes straight from armed to done at the trigger edge.
- R6: In done, no further samples are written and the state stays done. `stat_trig_idx` then gives the buffer index of the trigger sample. In every other state it reads 0.
- R7: A `rd_req` with `rd_addr` at a clock edge returns that buffer entry on `rd_data`, with `rd_valid` high, after that edge. One cycle later `rd_valid` is low again if no request is made.
- R8: Writing 1 to bit 0 of the command register arms the core from any state. The state becomes armed, the write index returns to 0 and the reported trigger index is cleared.
- R9: Host register select `host_sel`: 0 = compare value, 1 = mask, 2 = post-trigger count (only the low ADDR_W+1 bits of `host_wdata` are kept), 3 = command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Design clock; probes are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| probe_i | input | PROBE_W | Probed internal nodes |
| host_wr | input | 1 | Host register write strobe |
| host_sel | input | 2 | Host register select |
| host_wdata | input | PROBE_W | Host write data |
| stat_state | output | 2 | Capture state (0 idle, 1 armed, 2 triggered, 3 done) |
| stat_trig_idx | output | ADDR_W | Buffer index of the trigger sample, valid in done |
| rd_req | input | 1 | Trace read strobe |
| rd_addr | input | ADDR_W | Trace read index |
| rd_data | output | PROBE_W | Trace read data, one cycle after the strobe |
| rd_valid | output | 1 | High in the cycle `rd_data` holds a requested entry |

## Verification
The bench sweeps the post-trigger count across its whole range, including zero and values above the clamp. A design with an off-by-one in the post-trigger countdown would stop early or late, and the state timeline and readout would show it. Triggers land both before and after the buffer first wraps. A pointer that failed to wrap, or a wrong trigger index, would put samples at the wrong addresses. Partial masks and an all-zero mask check that don't-care bits are ignored and that a trigger on the very first sample is caught. Extra cycles in done, with new probe values, catch a core that keeps writing and overwrites the captured trace.

// File: rtl/trc_pkg.sv
package trc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_TRIGD = 2'd2,
      ST_DONE  = 2'd3
   } trc_state_e;

   localparam logic [1:0] SEL_VALUE = 2'd0;
   localparam logic [1:0] SEL_MASK  = 2'd1;
   localparam logic [1:0] SEL_POST  = 2'd2;
   localparam logic [1:0] SEL_CMD   = 2'd3;
endpackage

// File: rtl/trc_trigger.sv
module trc_trigger #(
   parameter int W = 8
) (
   input  logic [W-1:0] probe,
   input  logic [W-1:0] value,
   input  logic [W-1:0] mask,
   output logic         hit
);
   logic [W-1:0] bit_ok;

   // per-bit compare, a cleared mask bit always agrees
   for (genvar b = 0; b < W; b++) begin : g_bit
      assign bit_ok[b] = ~mask[b] | ~(probe[b] ^ value[b]);
   end

   assign hit = &bit_ok;
endmodule

// File: rtl/trc_buffer.sv
module trc_buffer #(
   parameter int W     = 8,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata,
   output logic          rvalid
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (re) rdata <= mem[raddr];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rvalid <= 1'b0;
      else        rvalid <= re;
   end

   // R7: data comes back exactly one edge after the strobe
   p_rd_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
      re |=> rvalid);
   p_rd_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !re |=> !rvalid);
endmodule

// File: rtl/trc_sequencer.sv
module trc_sequencer
   import trc_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          arm,
   input  logic          hit,
   input  logic [CW-1:0] post_cnt,
   output trc_state_e    state,
   output logic          wr_en,
   output logic [AW-1:0] wr_ptr,
   output logic [AW-1:0] trig_idx
);
   localparam logic [CW-1:0] POST_MAX = CW'(DEPTH - 1);

   logic [CW-1:0] post_eff;
   logic [CW-1:0] rem;
   logic [AW-1:0] ptr_nxt;
   logic [AW-1:0] trig_q;

   // keep the trigger sample from being overwritten by post-trigger samples
   assign post_eff = (post_cnt > POST_MAX) ? POST_MAX : post_cnt;

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign ptr_nxt = wr_ptr + 1'b1;
   end else begin : g_wrap
      assign ptr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
   end

   assign wr_en = !arm && ((state == ST_ARMED) || (state == ST_TRIGD));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         wr_ptr <= '0;
         rem    <= '0;
         trig_q <= '0;
      end else if (arm) begin
         state  <= ST_ARMED;
         wr_ptr <= '0;
         rem    <= '0;
         trig_q <= '0;
      end else begin
         case (state)
            ST_ARMED: begin
               wr_ptr <= ptr_nxt;
               if (hit) begin
                  trig_q <= wr_ptr;
                  if (post_eff == '0) begin
                     state <= ST_DONE;
                  end else begin
                     state <= ST_TRIGD;
                     rem   <= post_eff;
                  end
               end
            end
            ST_TRIGD: begin
               wr_ptr <= ptr_nxt;
               rem    <= rem - 1'b1;
               if (rem == CW'(1)) state <= ST_DONE;
            end
            default: ;
         endcase
      end
   end

   assign trig_idx = (state == ST_DONE) ? trig_q : '0;

   // R8: arming always restarts from index 0
   p_arm_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> (state == ST_ARMED && wr_ptr == '0));
   // R6: done holds and the write index freezes
   p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DONE && !arm) |=> (state == ST_DONE && $stable(wr_ptr)));
   // R2: idle without an arm stays idle
   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && !arm) |=> state == ST_IDLE);
   // R3: no match, no trigger
   p_hold_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ARMED && !arm && !hit) |=> state == ST_ARMED);
   // R5: the remaining count stays within the clamp while triggered
   p_rem_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TRIGD) |-> (rem != '0 && rem <= POST_MAX));
endmodule

// File: rtl/trc_capture_core.sv
module trc_capture_core
   import trc_pkg::*;
#(
   parameter int PROBE_W = 8,
   parameter int DEPTH   = 16,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int CNT_W  = ADDR_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PROBE_W-1:0] probe_i,
   input  logic               host_wr,
   input  logic [1:0]         host_sel,
   input  logic [PROBE_W-1:0] host_wdata,
   output logic [1:0]         stat_state,
   output logic [ADDR_W-1:0]  stat_trig_idx,
   input  logic               rd_req,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [PROBE_W-1:0] rd_data,
   output logic               rd_valid
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("trc_capture_core: DEPTH must be at least 2");
   end
   if (PROBE_W < CNT_W) begin : g_bad_width
      $error("trc_capture_core: PROBE_W must hold the post-trigger count");
   end

   logic [PROBE_W-1:0] value_q;
   logic [PROBE_W-1:0] mask_q;
   logic [CNT_W-1:0]   post_q;
   logic               arm;
   logic               hit;
   logic               wr_en;
   logic [ADDR_W-1:0]  wr_ptr;
   trc_state_e         state;

   assign arm = host_wr && (host_sel == SEL_CMD) && host_wdata[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         value_q <= '0;
         mask_q  <= '0;
         post_q  <= '0;
      end else if (host_wr) begin
         case (host_sel)
            SEL_VALUE: value_q <= host_wdata;
            SEL_MASK:  mask_q  <= host_wdata;
            SEL_POST:  post_q  <= host_wdata[CNT_W-1:0];
            default: ;
         endcase
      end
   end

   trc_trigger #(.W(PROBE_W)) trig_i (
      .probe (probe_i),
      .value (value_q),
      .mask  (mask_q),
      .hit   (hit)
   );

   trc_sequencer #(.DEPTH(DEPTH)) seq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (arm),
      .hit      (hit),
      .post_cnt (post_q),
      .state    (state),
      .wr_en    (wr_en),
      .wr_ptr   (wr_ptr),
      .trig_idx (stat_trig_idx)
   );

   trc_buffer #(.W(PROBE_W), .DEPTH(DEPTH)) buf_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (wr_en),
      .waddr  (wr_ptr),
      .wdata  (probe_i),
      .re     (rd_req),
      .raddr  (rd_addr),
      .rdata  (rd_data),
      .rvalid (rd_valid)
   );

   assign stat_state = state;

   // R3: a matching sample while armed leaves the armed state
   p_match_leaves_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ARMED && !arm && ((probe_i & mask_q) == (value_q & mask_q)))
      |=> (state == ST_TRIGD || state == ST_DONE));
   // R6: trigger index is zero outside done
   p_idx_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_state != 2'd3) |-> (stat_trig_idx == '0));
endmodule

// File: tb/trc_capture_core_tb_top.sv
`timescale 1ns/1ps
module trc_capture_core_tb_top;
   localparam int PW    = 8;
   localparam int DEPTH = 16;
   localparam int AW    = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [PW-1:0] probe_i = '0;
   logic          host_wr = 1'b0;
   logic [1:0]    host_sel = '0;
   logic [PW-1:0] host_wdata = '0;
   logic [1:0]    stat_state;
   logic [AW-1:0] stat_trig_idx;
   logic          rd_req = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [PW-1:0] rd_data;
   logic          rd_valid;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   trc_capture_core #(.PROBE_W(PW), .DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .probe_i(probe_i),
      .host_wr(host_wr), .host_sel(host_sel), .host_wdata(host_wdata),
      .stat_state(stat_state), .stat_trig_idx(stat_trig_idx),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic hwrite(input logic [1:0] sel, input int data);
      @(negedge clk);
      host_wr = 1'b1; host_sel = sel; host_wdata = PW'(data);
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   function automatic int pv(input int i, input int k, input int off);
      return (i * k + off) & 255;
   endfunction

   // one full capture: configure, arm, run, verify timeline and readout
   task automatic run_cap(input int tval, input int msk, input int post,
                          input int k, input int off);
      int it, pe, last;
      it = -1;
      for (int i = 0; i < 256; i++)
         if (it < 0 && ((pv(i, k, off) & msk) == (tval & msk))) it = i;
      pe = ((post & 31) > DEPTH - 1) ? DEPTH - 1 : (post & 31);
      last = it + pe;
      hwrite(2'd0, tval);
      hwrite(2'd1, msk);
      hwrite(2'd2, post);
      hwrite(2'd3, 1);
      chk("R8 state after arm", int'(stat_state), 1);
      chk("R8 trig idx cleared", int'(stat_trig_idx), 0);
      for (int i = 0; i <= last; i++) begin
         probe_i = PW'(pv(i, k, off));
         @(negedge clk);
         if (i < it)         chk("R3 armed before match", int'(stat_state), 1);
         else if (i < last)  chk("R5 triggered during post", int'(stat_state), 2);
         else                chk("R5 done at last sample", int'(stat_state), 3);
      end
      for (int j = 0; j < 4; j++) begin
         probe_i = PW'(~pv(j, 7, 1));
         @(negedge clk);
      end
      chk("R6 stays done", int'(stat_state), 3);
      chk("R6 trigger index", int'(stat_trig_idx), it % DEPTH);
      for (int a = 0; a < DEPTH; a++) begin
         int si;
         rd_req = 1'b1; rd_addr = AW'(a);
         @(negedge clk);
         rd_req = 1'b0;
         chk("R7 valid after strobe", int'(rd_valid), 1);
         si = last - (((last - a) % DEPTH + DEPTH) % DEPTH);
         if (si >= 0) chk("R4 buffer content", int'(rd_data), pv(si, k, off));
      end
      @(negedge clk);
      chk("R7 valid drops", int'(rd_valid), 0);
   endtask

   initial begin
      #(8.0 * 200000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset state", int'(stat_state), 0);
      chk("R1 reset trig idx", int'(stat_trig_idx), 0);
      chk("R1 reset rd_valid", int'(rd_valid), 0);
      rst_n = 1'b1;
      // R2: mask 0 would match anything, but the core is not armed
      for (int i = 0; i < 6; i++) begin
         probe_i = PW'(i * 37);
         @(negedge clk);
      end
      chk("R2 idle without arm", int'(stat_state), 0);
      run_cap(pv(20, 1, 0), 8'hFF, 4, 1, 0);       // R4 wrap before trigger
      run_cap(8'h00, 8'h00, 6, 5, 9);               // R3 all don't-care, first sample
      run_cap(pv(5, 3, 2), 8'hFF, 0, 3, 2);         // R5 zero post count
      run_cap(pv(9, 1, 40), 8'hFF, 31, 1, 40);      // R5 clamp to DEPTH-1
      run_cap(8'h03, 8'h0F, 8'hE4, 3, 7);           // R3 partial mask, R9 low bits kept
      for (int p = 0; p < 18; p++)                  // R5 sweep of post count
         run_cap(pv(p + 2, 5, p * 11), 8'hFF, p, 5, p * 11);
      for (int t = 14; t < 40; t += 5)              // R4 trigger across the wrap
         run_cap(pv(t, 7, 3), 8'hFF, 3, 7, 3);
      // R8 arming while armed restarts
      hwrite(2'd1, 8'hFF);
      hwrite(2'd0, 8'hAA);
      probe_i = 8'h00;
      hwrite(2'd3, 1);
      hwrite(2'd3, 1);
      chk("R8 re-arm while armed", int'(stat_state), 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule